// File: doc/BRIEF.md
# Multi-Channel PWM Generator with Register Access

This block generates several independent pulse-width-modulated outputs. Each output is programmed over a simple single-cycle register bus. Every channel has its own register window, which holds a control word, a period count and a high-time threshold. One shared word holds the run-enable bits of all channels. The control word carries a power-of-two clock divider exponent and a run flag. Each channel counts divided ticks from zero up to its period and then wraps. Its output stays high while the count is below the threshold.

Software programs a channel while it is stopped and then sets the channel's enable bit. Configuration changes made while a channel runs are held back until the channel's current period ends, so the waveform never shows a shortened cycle. A global clock-select word chooses the tick source. One setting advances the prescalers on every input clock. The other advances them only on cycles where an external reference strobe is high. A build option moves the period and threshold registers of the channels with index 3 and above up by one word.

Top module: `pwm_bank`

## Requirements
- R1: The word at offset 0x000 holds the channel enable bits, with bit i enabling channel i. It reads back the written value, and bits at or above the channel count read 0. All enables and all outputs are 0 after reset.
- R2: Channel i (i from 0 to 6) has its register window at 0x010 + 0x040*i, and channel 7 has its window at 0x220.
- R3: The control word sits at window offset 0x00. Bits [2:0] hold the divider exponent and bit 15 is the run flag; every other bit reads 0. A channel drives a waveform only while both its enable bit and its run flag are set; otherwise its output is 0.
- R4: The period count is at window offset 0x2C and the threshold at 0x30. Each is 13 bits wide (0 to 8191). Bits above 12 are dropped on write and read as 0.
- R5: With the alternate map option set, channels 3 and above hold the period at window offset 0x30 and the threshold at 0x34, and their offset 0x2C is unmapped. Channels 0 to 2 keep the default layout.
- R6: The channel count advances once every 2^div tick-source cycles and wraps to 0 after reaching period-1. On the cycle after the enable write, the count is 0. The output is high exactly while count < threshold.
- R7: A threshold at or above the period holds the output high. A threshold of 0 holds it low. A period of 0 behaves like a period of 1.
- R8: Writes to the period, threshold, divider or run flag of a running channel take effect only when its count wraps.
- R9: Clearing a channel's enable bit drives its output low from the clock edge of that write, and returns its count and prescaler to 0. The next enable restarts the waveform from phase 0.
- R10: Bit 0 of the word at 0x210 selects the tick source. A value of 0 means every input clock cycle is a tick. A value of 1 means only cycles with ref_tick high are ticks. The word reads back in bit 0 and resets to 0.
- R11: Reads return data on rd_data in the cycle after the request. Reads of unmapped offsets return 0, and writes to them change nothing. rd_data is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| ref_tick | input | 1 | Alternate tick strobe used when the clock select is 1 |
| pwm_o | output | NCH | Active-high channel outputs |

## Verification
The assertions assume the following about the inputs:
- At most one request arrives per cycle.
- ref_tick is a clean synchronous strobe.
- Reset is asserted at the start of a run.

Under these assumptions, the prescaler never passes its limit, the count stays below the active period, and the active configuration never changes mid-period. The stimulus drives every bus request and ref_tick only on falling edges and holds each request for exactly one rising edge. Random configurations are drawn from $urandom with a fixed seed and kept to small dividers and periods, so that every random waveform is compared over two full periods within the cycle budget. Directed cases cover the threshold extremes, a zero period, a mid-period rewrite, the irregular last window and the strobe-driven tick source.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int unsigned GLB_EN_OFS  = 'h000;
   localparam int unsigned CLK_SEL_OFS = 'h210;
   localparam int unsigned CTRL_OFS    = 'h00;
   localparam int unsigned PER_OFS     = 'h2C;
   localparam int unsigned THR_OFS     = 'h30;
   localparam int unsigned PER_OFS_ALT = 'h30;
   localparam int unsigned THR_OFS_ALT = 'h34;
   localparam int unsigned RUN_BIT     = 15;
   localparam int unsigned MAX_CH      = 8;
   localparam int unsigned LAST_BASE   = 'h220;

   // windows follow a 0x40 stride except the last one
   function automatic int unsigned chan_base(int unsigned ch);
      return (ch < MAX_CH - 1) ? ('h010 + 'h040 * ch) : LAST_BASE;
   endfunction

   function automatic int unsigned per_ofs(int unsigned ch, bit alt);
      return (alt && ch > 2) ? PER_OFS_ALT : PER_OFS;
   endfunction

   function automatic int unsigned thr_ofs(int unsigned ch, bit alt);
      return (alt && ch > 2) ? THR_OFS_ALT : THR_OFS;
   endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 13,
   parameter int unsigned DIV_W       = 3,
   parameter bit          ALT_MAP     = 1'b0,
   parameter bit          HAS_REF_SEL = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic                        req_write,
   input  logic [ADDR_W-1:0]           req_addr,
   input  logic [DATA_W-1:0]           req_wdata,
   output logic [DATA_W-1:0]           rd_data,
   output logic [NCH-1:0]              en_o,
   output logic                        sel_o,
   output logic [NCH-1:0]              mode_o,
   output logic [NCH-1:0][DIV_W-1:0]   div_o,
   output logic [NCH-1:0][CNT_W-1:0]   per_o,
   output logic [NCH-1:0][CNT_W-1:0]   thr_o
);

   localparam logic [ADDR_W-1:0] EN_A  = ADDR_W'(GLB_EN_OFS);
   localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(CLK_SEL_OFS);

   logic [NCH-1:0]            en_q;
   logic                      sel_q;
   logic [NCH-1:0]            mode_q;
   logic [NCH-1:0][DIV_W-1:0] div_q;
   logic [NCH-1:0][CNT_W-1:0] per_q;
   logic [NCH-1:0][CNT_W-1:0] thr_q;
   logic [DATA_W-1:0]         rd_q;
   logic [DATA_W-1:0]         rd_next;
   logic                      wr_go;
   logic                      rd_go;

   assign wr_go = req_valid &  req_write;
   assign rd_go = req_valid & ~req_write;

   // read decode: flat address compares, zero when nothing matches
   always_comb begin
      rd_next = '0;
      if (req_addr == EN_A) rd_next[NCH-1:0] = en_q;
      if (HAS_REF_SEL && req_addr == SEL_A) rd_next[0] = sel_q;
      for (int c = 0; c < NCH; c++) begin
         if (req_addr == ADDR_W'(chan_base(unsigned'(c)) + CTRL_OFS)) begin
            rd_next[RUN_BIT]     = mode_q[c];
            rd_next[DIV_W-1:0]   = div_q[c];
         end
         if (req_addr == ADDR_W'(chan_base(unsigned'(c)) + per_ofs(unsigned'(c), ALT_MAP)))
            rd_next[CNT_W-1:0] = per_q[c];
         if (req_addr == ADDR_W'(chan_base(unsigned'(c)) + thr_ofs(unsigned'(c), ALT_MAP)))
            rd_next[CNT_W-1:0] = thr_q[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         sel_q  <= 1'b0;
         mode_q <= '0;
         div_q  <= '0;
         per_q  <= '0;
         thr_q  <= '0;
         rd_q   <= '0;
      end else begin
         rd_q <= rd_go ? rd_next : '0;
         if (wr_go) begin
            if (req_addr == EN_A) en_q <= req_wdata[NCH-1:0];
            if (HAS_REF_SEL && req_addr == SEL_A) sel_q <= req_wdata[0];
            for (int c = 0; c < NCH; c++) begin
               if (req_addr == ADDR_W'(chan_base(unsigned'(c)) + CTRL_OFS)) begin
                  mode_q[c] <= req_wdata[RUN_BIT];
                  div_q[c]  <= req_wdata[DIV_W-1:0];
               end
               if (req_addr == ADDR_W'(chan_base(unsigned'(c)) + per_ofs(unsigned'(c), ALT_MAP)))
                  per_q[c] <= req_wdata[CNT_W-1:0];
               if (req_addr == ADDR_W'(chan_base(unsigned'(c)) + thr_ofs(unsigned'(c), ALT_MAP)))
                  thr_q[c] <= req_wdata[CNT_W-1:0];
            end
         end
      end
   end

   assign rd_data = rd_q;
   assign en_o    = en_q;
   assign sel_o   = sel_q;
   assign mode_o  = mode_q;
   assign div_o   = div_q;
   assign per_o   = per_q;
   assign thr_o   = thr_q;

   // R11: no read request means zero read data next cycle
   a_r11_idle_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_go |=> (rd_data == '0));

   // R1: enable word only moves on a bus write
   a_r1_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_go |=> $stable(en_o));

   // R10: clock select only moves on a bus write
   a_r10_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_go |=> $stable(sel_o));

endmodule

// File: rtl/pwm_bank_presc.sv
module pwm_bank_presc #(
   parameter int unsigned DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick_in,
   input  logic [DIV_W-1:0] div,
   output logic             step
);

   localparam int unsigned PRE_W = (1 << DIV_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] lim;

   // limit is 2^div - 1: div low bits set
   assign lim  = ~({PRE_W{1'b1}} << div);
   assign step = tick_in & (pre_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_q <= '0;
      else if (clear)    pre_q <= '0;
      else if (tick_in)  pre_q <= step ? '0 : pre_q + 1'b1;
   end

   // R6: prescaler never runs past the divider limit
   a_r6_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= lim);

   // R9: a cleared prescaler restarts from zero
   a_r9_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (pre_q == '0));

endmodule

// File: rtl/pwm_bank_lane.sv
module pwm_bank_lane #(
   parameter int unsigned CNT_W = 13,
   parameter int unsigned DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             tick_in,
   input  logic             cfg_mode,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [CNT_W-1:0] cfg_per,
   input  logic [CNT_W-1:0] cfg_thr,
   output logic             pwm_o
);

   localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

   logic             sh_mode;
   logic [DIV_W-1:0] sh_div;
   logic [CNT_W-1:0] sh_per;
   logic [CNT_W-1:0] sh_thr;
   logic [CNT_W-1:0] cnt_q;
   logic             active;
   logic             step;
   logic             wrap;

   assign active = run_en & sh_mode;
   assign wrap   = ({1'b0, cnt_q} + ONE) >= {1'b0, sh_per};

   pwm_bank_presc #(.DIV_W(DIV_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (~active),
      .tick_in (tick_in),
      .div     (sh_div),
      .step    (step)
   );

   // shadow copy follows the registers while idle, reloads only on wrap
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_mode <= 1'b0;
         sh_div  <= '0;
         sh_per  <= '0;
         sh_thr  <= '0;
         cnt_q   <= '0;
      end else if (!active || (step && wrap)) begin
         sh_mode <= cfg_mode;
         sh_div  <= cfg_div;
         sh_per  <= cfg_per;
         sh_thr  <= cfg_thr;
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign pwm_o = active & (cnt_q < sh_thr);

   // R9: a disabled lane holds its count at zero
   a_r9_cnt_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (cnt_q == '0));

   // R6: count stays below the active period
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) || (cnt_q < sh_per));

   // R8: mid-period the active settings do not move
   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(active) && active && cnt_q != '0) |-> ($stable(sh_per) && $stable(sh_thr) && $stable(sh_div)));

   // R7: threshold at or above a nonzero period keeps the output high
   a_r7_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      (active && sh_per != '0 && sh_thr >= sh_per) |-> pwm_o);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int unsigned NCH         = 8,
   parameter int unsigned ADDR_W      = 10,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 13,
   parameter int unsigned DIV_W       = 3,
   parameter bit          ALT_MAP     = 1'b0,
   parameter bit          HAS_REF_SEL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ref_tick,
   output logic [NCH-1:0]    pwm_o
);

   localparam int unsigned TOP_ADDR = LAST_BASE + THR_OFS_ALT;

   if (NCH < 1 || NCH > MAX_CH)
      $error("pwm_bank: NCH must be 1..%0d", MAX_CH);
   if (DIV_W < 1 || DIV_W > 4)
      $error("pwm_bank: DIV_W must be 1..4");
   if (CNT_W < 1 || CNT_W > RUN_BIT)
      $error("pwm_bank: CNT_W must be 1..%0d", RUN_BIT);
   if (DATA_W <= RUN_BIT || DATA_W < NCH)
      $error("pwm_bank: DATA_W too narrow");
   if ((1 << ADDR_W) <= TOP_ADDR)
      $error("pwm_bank: ADDR_W too narrow for the register map");

   logic [NCH-1:0]            en_w;
   logic                      sel_w;
   logic [NCH-1:0]            mode_w;
   logic [NCH-1:0][DIV_W-1:0] div_w;
   logic [NCH-1:0][CNT_W-1:0] per_w;
   logic [NCH-1:0][CNT_W-1:0] thr_w;
   logic                      tick_src;

   pwm_bank_regs #(
      .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .DIV_W(DIV_W), .ALT_MAP(ALT_MAP), .HAS_REF_SEL(HAS_REF_SEL)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rd_data   (rd_data),
      .en_o      (en_w),
      .sel_o     (sel_w),
      .mode_o    (mode_w),
      .div_o     (div_w),
      .per_o     (per_w),
      .thr_o     (thr_w)
   );

   if (HAS_REF_SEL) begin : g_ref_sel
      assign tick_src = sel_w ? ref_tick : 1'b1;
   end else begin : g_clk_only
      assign tick_src = 1'b1 | (sel_w & ref_tick);
   end

   for (genvar c = 0; c < NCH; c++) begin : g_lane
      pwm_bank_lane #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .run_en   (en_w[c]),
         .tick_in  (tick_src),
         .cfg_mode (mode_w[c]),
         .cfg_div  (div_w[c]),
         .cfg_per  (per_w[c]),
         .cfg_thr  (thr_w[c]),
         .pwm_o    (pwm_o[c])
      );
   end

   // R9: an output whose enable was clear stays low
   a_r9_out_low: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pwm_o & ~en_w) && ((pwm_o & ~en_w) == '0));

endmodule

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;

   localparam int NCH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [9:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        ref_tick = 1'b0;
   logic [31:0] rd_data, rd_alt;
   logic [7:0]  pwm_o, pwm_alt;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   pwm_bank u_pwm_bank (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
      .ref_tick(ref_tick), .pwm_o(pwm_o));

   pwm_bank #(.ALT_MAP(1'b1)) u_pwm_bank_alt (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_alt),
      .ref_tick(ref_tick), .pwm_o(pwm_alt));

   function automatic int base(int c);
      return (c < 7) ? ('h10 + 'h40 * c) : 'h220;
   endfunction

   function automatic bit exp_lvl(int n, int dv, int per, int thr);
      int p;
      p = (per == 0) ? 1 : per;
      return ((n >> dv) % p) < thr;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 10'(a); req_wdata = d;
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d, output logic [31:0] da);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 10'(a);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      d = rd_data; da = rd_alt;
   endtask

   task automatic run_wave(int c, int dv, int per, int thr, string req);
      int bad, win;
      wr(base(c), 32'h8000 | 32'(dv));
      wr(base(c) + 'h2C, 32'(per));
      wr(base(c) + 'h30, 32'(thr));
      wr(0, 32'(1) << c);
      win = (((per == 0) ? 1 : per) << dv) * 2 + 3;
      bad = 0;
      for (int t = 0; t < win; t++) begin
         if (pwm_o[c] !== exp_lvl(t, dv, per, thr)) bad++;
         if ((pwm_o & ~(8'(1) << c)) != 8'h0) bad++;
         @(negedge clk);
      end
      chk(req, 32'(bad), 32'h0);
      wr(0, 32'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d, da;
      int rs, bad, n;
      rs = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 reset pwm", 32'(pwm_o), 32'h0);
      rd(0, d, da);            chk("R1 reset enable", d, 32'h0);
      rd('h210, d, da);        chk("R10 reset clksel", d, 32'h0);
      rd(base(0), d, da);      chk("R3 reset ctrl", d, 32'h0);

      // R1 enable word, R3 run flag clear keeps outputs low
      wr(0, 32'hFFFF_FFFF);
      rd(0, d, da);            chk("R1 enable readback", d, 32'hFF);
      chk("R3 no run flag low", 32'(pwm_o), 32'h0);
      wr(0, 32'h0);
      rd(0, d, da);            chk("R1 enable cleared", d, 32'h0);

      // R2/R4 window placement and 13-bit fields
      for (int c = 0; c < NCH; c++) begin
         wr(base(c) + 'h2C, 32'hFFFF_E000 | 32'(c * 17 + 1));
         wr(base(c) + 'h30, 32'hFFFF_E000 | 32'(c * 5 + 2));
      end
      for (int c = 0; c < NCH; c++) begin
         rd(base(c) + 'h2C, d, da); chk("R2 R4 period readback", d, 32'(c * 17 + 1));
         rd(base(c) + 'h30, d, da); chk("R2 R4 thresh readback", d, 32'(c * 5 + 2));
      end
      wr(base(7), 32'hFFFF_FFFF);
      rd(base(7), d, da);      chk("R3 ctrl field mask", d, 32'h8007);
      wr(base(7), 32'h0);
      wr(base(5) + 'h2C, 32'h1FFF);
      rd(base(5) + 'h2C, d, da); chk("R4 max period", d, 32'h1FFF);

      // R5 alternate map (shared writes: alt took the threshold values as period)
      rd(base(3) + 'h30, d, da); chk("R5 alt period at 0x30", da, 32'(3 * 5 + 2));
      rd(base(3) + 'h2C, d, da); chk("R5 alt 0x2C unmapped", da, 32'h0);
      wr(base(4) + 'h34, 32'd123);
      rd(base(4) + 'h34, d, da);
      chk("R5 alt thresh at 0x34", da, 32'd123);
      chk("R11 default 0x34 unmapped", d, 32'h0);
      rd(base(2) + 'h2C, d, da); chk("R5 alt low channel kept", da, 32'(2 * 17 + 1));

      // R11 unmapped offsets
      rd('h004, d, da);        chk("R11 unmapped read", d, 32'h0);
      rd('h3FC, d, da);        chk("R11 unmapped high read", d, 32'h0);
      wr('h004, 32'hFF);
      rd(0, d, da);            chk("R11 unmapped write ignored", d, 32'h0);
      chk("R11 unmapped write outputs", 32'(pwm_o), 32'h0);

      // R6 random waveforms
      for (int i = 0; i < 12; i++) begin
         int c, dv, per, thr;
         c   = int'($urandom % 8);
         dv  = int'($urandom % 4);
         per = 1 + int'($urandom % 24);
         thr = int'($urandom % (per + 3));
         run_wave(c, dv, per, thr, "R6 random waveform");
      end
      run_wave(7, 0, 10, 3, "R2 R6 last window waveform");

      // R7 corner thresholds and zero period
      run_wave(1, 0, 5, 5, "R7 thr equals period high");
      run_wave(1, 1, 5, 9, "R7 thr above period high");
      run_wave(1, 0, 5, 0, "R7 thr zero low");
      run_wave(6, 0, 0, 1, "R7 zero period acts as one");
      run_wave(6, 2, 0, 0, "R7 zero period thr zero low");

      // R8 period rewrite mid-period on channel 7
      wr(base(7), 32'h8000);
      wr(base(7) + 'h2C, 32'd10);
      wr(base(7) + 'h30, 32'd3);
      wr(0, 32'h80);
      bad = 0;
      for (int t = 0; t < 40; t++) begin
         bit e;
         e = (t < 10) ? ((t % 10) < 3) : (((t - 10) % 6) < 3);
         if (pwm_o[7] !== e) bad++;
         if (t == 4) begin
            req_valid = 1'b1; req_write = 1'b1;
            req_addr = 10'(base(7) + 'h2C); req_wdata = 32'd6;
         end
         if (t == 5) begin req_valid = 1'b0; req_write = 1'b0; end
         @(negedge clk);
      end
      chk("R8 deferred period change", 32'(bad), 32'h0);
      wr(0, 32'h0);

      // R9 disable mid-run then restart from phase 0
      wr(base(2), 32'h8001);
      wr(base(2) + 'h2C, 32'd7);
      wr(base(2) + 'h30, 32'd4);
      wr(0, 32'h4);
      repeat (5) @(negedge clk);
      chk("R9 running high", 32'(pwm_o[2]), 32'h1);
      wr(0, 32'h0);
      chk("R9 low after disable", 32'(pwm_o), 32'h0);
      run_wave(2, 1, 7, 4, "R9 restart phase zero");

      // R3 run flag set while enabled
      wr(base(0), 32'h0000);
      wr(base(0) + 'h2C, 32'd4);
      wr(base(0) + 'h30, 32'd2);
      wr(0, 32'h1);
      repeat (4) @(negedge clk);
      chk("R3 enabled without run flag low", 32'(pwm_o), 32'h0);
      wr(base(0), 32'h8000);
      @(negedge clk);
      bad = 0;
      for (int t = 0; t < 12; t++) begin
         if (pwm_o[0] !== exp_lvl(t, 0, 4, 2)) bad++;
         @(negedge clk);
      end
      chk("R3 run flag starts waveform", 32'(bad), 32'h0);
      wr(0, 32'h0);

      // R10 strobe tick source
      wr('h210, 32'h1);
      rd('h210, d, da);        chk("R10 clksel readback", d, 32'h1);
      wr(base(1), 32'h8001);
      wr(base(1) + 'h2C, 32'd5);
      wr(base(1) + 'h30, 32'd2);
      wr(0, 32'h2);
      bad = 0; n = 0;
      for (int t = 0; t < 90; t++) begin
         bit rt;
         if (pwm_o[1] !== exp_lvl(n, 1, 5, 2)) bad++;
         rt = 1'($urandom % 2);
         ref_tick = rt;
         @(negedge clk);
         n += int'(rt);
      end
      ref_tick = 1'b0;
      chk("R10 strobe ticks", 32'(bad), 32'h0);
      wr(0, 32'h0);
      wr('h210, 32'h0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule